// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block is a register-mapped port that exposes a read-only table of configuration items to a host. Each item has a byte length and byte contents, and the items sit in two banks. The host first writes a 16-bit key to the control register. That write chooses an item and rewinds the read position to the start. Reads of the data register then return the item's bytes one after another. Once the item is exhausted, zeros are returned. A read can be 1, 2, 4 or 8 bytes wide, up to the data register width. A multi-byte read puts the earliest item byte in the most significant byte of the result. When the item ends part-way through a read, the missing low-order bytes are zero.

The item table is a small constant memory that is filled at elaboration. Item (bank 0, index 0) is a fixed 4-byte signature. Every other item has a computed length, and its bytes are computed from bank, index and offset. A parameter selects a combined variant with a single address. In that variant, the width of the access decides what it does: a byte access is a data access and a 16-bit write is a key write. A one-cycle `select_pulse` marks every successful selection, so that outside logic can refresh the chosen item.

Top module: `cfg_item_port`

## Requirements
- R1: While `rst` is high, `req_ready`, `rsp_valid`, `rsp_data` and `select_pulse` are 0. After reset, the item in bank 0 at index 0 is selected with offset 0, so a 4-byte data read returns 32'h4B434647.
- R2: A key write sets the read offset to 0, whether the key is valid or not. Selecting the same item again replays its bytes from the start.
- R3: Key bit 15 selects the bank (0 or 1). Key bits 14:0 give the index within that bank.
- R4: When the index is at or above ENTRY_COUNT, the selection is invalid. Every later data read returns 0 until the next valid key write, and no `select_pulse` is raised.
- R5: A data read of N bytes uses `req_size` code 0/1/2/3 for N = 1/2/4/8, with N no larger than DATA_BYTES. The result sits in the low N bytes of `rsp_data`, and the byte at the current offset is in the highest of those bytes. All bytes above the low N are 0. The offset advances by the number of item bytes returned.
- R6: When fewer than N item bytes remain, the remaining bytes are returned, the lower bytes are padded with 0, and the offset stops at the item length.
- R7: A read with the offset already at the item length, or a read of a zero-length item, returns 0 and leaves the offset unchanged.
- R8: In the split variant (COMBINED=0), `req_addr` 0 is the control register and `req_addr` 1 is the data register. Only a 2-byte write (size code 1) to control is a key write. Control writes of any other size have no effect, and control reads return 0.
- R9: Writes to the data register have no effect on the selection or the offset.
- R10: A data read wider than DATA_BYTES returns 0 and leaves the offset unchanged.
- R11: `select_pulse` is high for exactly the one cycle after each key write that selects a valid item.
- R12: In the combined variant (COMBINED=1), `req_addr` is ignored. A size code 0 read is a data read, and a size code 1 write is a key write. Every other read returns 0, and every other write has no effect.
- R13: `req_ready` is 1 whenever `rst` is low. `rsp_valid` is high for exactly the one cycle after each accepted read, and `rsp_data` carries that read's result. `rsp_data` is 0 when no response is given.
- R14: Item (b, i) has length 4 for b=0, i=0. Its length is 0 for b=1, i=ENTRY_COUNT-1. Otherwise its length is (5*i + 3*b) mod (MAX_LEN+1). Its byte at offset o is ((128*b + 16*i + o) XOR 8'h5A) mod 256, except for the signature bytes 4B, 43, 46, 47.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | Register select in the split variant (0 control, 1 data) |
| req_size | input | 2 | log2 of the access width in bytes |
| req_wdata | input | 16 | Write data; the key on control writes |
| rsp_valid | output | 1 | Read result valid |
| rsp_data | output | DATA_BYTES*8 | Read result |
| select_pulse | output | 1 | One-cycle strobe after a valid selection |

## Verification
The embedded properties assume a request is accepted only when `req_ready` is high. They also assume that `req_size` and `req_write` are stable within the accepted cycle, and that the item table is constant. The bench changes inputs only on the falling edge, holds `req_valid` low throughout reset, and drives both variants with one shared request stream. Directed keys cover both banks, an index just past the end of the table, the zero-length item and the key with all index bits set. A final seeded stretch mixes random widths, addresses and directions, using keys of which roughly one in five is invalid.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;

    localparam int KEY_W    = 16;
    localparam int BANK_BIT = 15;
    localparam logic [31:0] SIGNATURE = 32'h4B434647;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_SELECT,
        ACC_DATA_RD,
        ACC_ZERO_RD
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      sel_ok;
        logic      bank;
    } acc_dec_t;

    function automatic int item_len(input int bank, input int idx,
                                    input int entries, input int max_len);
        if (bank == 0 && idx == 0) return 4;
        if (bank == 1 && idx == entries - 1) return 0;
        return (idx * 5 + bank * 3) % (max_len + 1);
    endfunction

    function automatic logic [7:0] item_byte(input int bank, input int idx, input int off);
        logic [31:0] sig_sh;
        if (bank == 0 && idx == 0) begin
            sig_sh = SIGNATURE >> (8 * (3 - (off % 4)));
            return sig_sh[7:0];
        end
        return 8'((bank * 128 + idx * 16 + off) ^ 32'h5A);
    endfunction

endpackage

// File: rtl/cfg_access_decode.sv
module cfg_access_decode
    import cfg_item_pkg::*;
#(
    parameter int DATA_BYTES  = 8,
    parameter int ENTRY_COUNT = 8,
    parameter int IDX_W       = 3,
    parameter bit COMBINED    = 1'b0
) (
    input  logic             fire,
    input  logic             write,
    input  logic             addr,
    input  logic [1:0]       size,
    input  logic [KEY_W-1:0] wdata,
    output acc_dec_t         dec,
    output logic [IDX_W-1:0] sel_idx
);

    logic is_sel;
    logic is_data;
    logic rd_fits;

    generate
        if (COMBINED) begin : g_comb
            assign is_sel  = write && (size == 2'd1);
            assign is_data = (size == 2'd0);
        end else begin : g_split
            assign is_sel  = !addr && write && (size == 2'd1);
            assign is_data = addr;
        end
    endgenerate

    assign rd_fits = (32'd1 << size) <= 32'(DATA_BYTES);
    assign sel_idx = wdata[IDX_W-1:0];

    always_comb begin
        dec.kind   = ACC_NONE;
        dec.sel_ok = int'(wdata[BANK_BIT-1:0]) < ENTRY_COUNT;
        dec.bank   = wdata[BANK_BIT];
        if (fire) begin
            if (is_sel) begin
                dec.kind = ACC_SELECT;
            end else if (!write) begin
                dec.kind = (is_data && rd_fits) ? ACC_DATA_RD : ACC_ZERO_RD;
            end
        end
    end

endmodule

// File: rtl/cfg_item_store.sv
module cfg_item_store
    import cfg_item_pkg::*;
#(
    parameter int ENTRY_COUNT = 8,
    parameter int MAX_LEN     = 16,
    parameter int DATA_BYTES  = 8,
    parameter int IDX_W       = 3,
    parameter int OFF_W       = 5
) (
    input  logic                        bank,
    input  logic [IDX_W-1:0]            idx,
    input  logic [OFF_W-1:0]            off,
    output logic [OFF_W-1:0]            len,
    output logic [DATA_BYTES-1:0][7:0]  lanes
);

    localparam int POS_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    logic [7:0]       rom     [2][ENTRY_COUNT][MAX_LEN];
    logic [OFF_W-1:0] len_tab [2][ENTRY_COUNT];

    always_comb begin
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < ENTRY_COUNT; i++) begin
                len_tab[b][i] = OFF_W'(item_len(b, i, ENTRY_COUNT, MAX_LEN));
                for (int o = 0; o < MAX_LEN; o++) begin
                    rom[b][i][o] = (o < item_len(b, i, ENTRY_COUNT, MAX_LEN))
                                   ? item_byte(b, i, o) : 8'h00;
                end
            end
        end
    end

    assign len = len_tab[bank][idx];

    generate
        for (genvar k = 0; k < DATA_BYTES; k++) begin : g_lane
            logic [OFF_W:0] pos;
            assign pos = {1'b0, off} + (OFF_W+1)'(k);
            assign lanes[k] = (int'(pos) < MAX_LEN) ? rom[bank][idx][pos[POS_W-1:0]] : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/cfg_read_packer.sv
module cfg_read_packer #(
    parameter int DATA_BYTES = 8,
    parameter int OFF_W      = 5
) (
    input  logic                        valid,
    input  logic [OFF_W-1:0]            len,
    input  logic [OFF_W-1:0]            off,
    input  logic [1:0]                  size,
    input  logic [DATA_BYTES-1:0][7:0]  lanes,
    output logic [DATA_BYTES*8-1:0]     data,
    output logic [OFF_W-1:0]            take
);

    localparam int LW = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

    int unsigned n_bytes;
    int unsigned avail;
    int unsigned n_take;

    always_comb begin
        n_bytes = 32'd1 << size;
        avail   = (valid && (off < len)) ? int'(len) - int'(off) : 0;
        n_take  = (n_bytes < avail) ? n_bytes : avail;
        take    = OFF_W'(n_take);
        data    = '0;
        for (int p = 0; p < DATA_BYTES; p++) begin
            if (p < int'(n_bytes)) begin
                if ((int'(n_bytes) - 1 - p) < int'(n_take) &&
                    (int'(n_bytes) - 1 - p) < DATA_BYTES) begin
                    data[p*8 +: 8] = lanes[LW'(int'(n_bytes) - 1 - p)];
                end
            end
        end
    end

endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
    import cfg_item_pkg::*;
#(
    parameter int DATA_BYTES  = 8,
    parameter int ENTRY_COUNT = 8,
    parameter int MAX_LEN     = 16,
    parameter bit COMBINED    = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic                    req_addr,
    input  logic [1:0]              req_size,
    input  logic [15:0]             req_wdata,
    output logic                    rsp_valid,
    output logic [DATA_BYTES*8-1:0] rsp_data,
    output logic                    select_pulse
);

    localparam int IDX_W = (ENTRY_COUNT > 1) ? $clog2(ENTRY_COUNT) : 1;
    localparam int OFF_W = $clog2(MAX_LEN + 1);

    acc_dec_t                    dec;
    logic [IDX_W-1:0]            sel_idx;
    logic                        fire;

    logic                        cur_valid;
    logic                        cur_bank;
    logic [IDX_W-1:0]            cur_idx;
    logic [OFF_W-1:0]            cur_off;
    logic [OFF_W-1:0]            cur_len;
    logic [DATA_BYTES-1:0][7:0]  lanes;
    logic [DATA_BYTES*8-1:0]     pack_data;
    logic [OFF_W-1:0]            take;

    assign req_ready = ~rst;
    assign fire      = req_valid & req_ready;

    cfg_access_decode #(
        .DATA_BYTES (DATA_BYTES),
        .ENTRY_COUNT(ENTRY_COUNT),
        .IDX_W      (IDX_W),
        .COMBINED   (COMBINED)
    ) u_decode (
        .fire   (fire),
        .write  (req_write),
        .addr   (req_addr),
        .size   (req_size),
        .wdata  (req_wdata),
        .dec    (dec),
        .sel_idx(sel_idx)
    );

    cfg_item_store #(
        .ENTRY_COUNT(ENTRY_COUNT),
        .MAX_LEN    (MAX_LEN),
        .DATA_BYTES (DATA_BYTES),
        .IDX_W      (IDX_W),
        .OFF_W      (OFF_W)
    ) u_store (
        .bank (cur_bank),
        .idx  (cur_idx),
        .off  (cur_off),
        .len  (cur_len),
        .lanes(lanes)
    );

    cfg_read_packer #(
        .DATA_BYTES(DATA_BYTES),
        .OFF_W     (OFF_W)
    ) u_pack (
        .valid(cur_valid),
        .len  (cur_len),
        .off  (cur_off),
        .size (req_size),
        .lanes(lanes),
        .data (pack_data),
        .take (take)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_valid    <= 1'b1;
            cur_bank     <= 1'b0;
            cur_idx      <= '0;
            cur_off      <= '0;
            rsp_valid    <= 1'b0;
            rsp_data     <= '0;
            select_pulse <= 1'b0;
        end else begin
            rsp_valid    <= (dec.kind == ACC_DATA_RD) || (dec.kind == ACC_ZERO_RD);
            rsp_data     <= (dec.kind == ACC_DATA_RD) ? pack_data : '0;
            select_pulse <= (dec.kind == ACC_SELECT) && dec.sel_ok;
            case (dec.kind)
                ACC_SELECT: begin
                    cur_off   <= '0;
                    cur_valid <= dec.sel_ok;
                    if (dec.sel_ok) begin
                        cur_bank <= dec.bank;
                        cur_idx  <= sel_idx;
                    end
                end
                ACC_DATA_RD: cur_off <= cur_off + take;
                default: ;
            endcase
        end
    end

    assert_sel_rewind_R2: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == ACC_SELECT) |=> (cur_off == '0));

    assert_invalid_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == ACC_DATA_RD && !cur_valid) |=> (rsp_data == '0));

    assert_off_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cur_valid |-> (cur_off <= cur_len));

    assert_ignored_keeps_state_R9: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == ACC_NONE) |=> ($stable(cur_off) && $stable(cur_valid)));

    assert_wide_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == ACC_ZERO_RD) |=> ((rsp_data == '0) && $stable(cur_off)));

    assert_pulse_cause_R11: assert property (@(posedge clk) disable iff (rst)
        select_pulse |-> $past(dec.kind == ACC_SELECT));

    assert_rsp_follows_read_R13: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(fire && !req_write));

endmodule

// File: tb/cfg_item_port_bench.sv
`timescale 1ns/1ps
module cfg_item_port_bench;

    localparam int DB = 4;
    localparam int EC = 8;
    localparam int ML = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_addr  = 1'b0;
    logic [1:0]  req_size  = 2'd0;
    logic [15:0] req_wdata = 16'd0;

    logic [1:0]      rdy, rv, pulse;
    logic [DB*8-1:0] rd [2];

    cfg_item_port #(.DATA_BYTES(DB), .ENTRY_COUNT(EC), .MAX_LEN(ML), .COMBINED(1'b0)) u_cfg_item_port (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[0]),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rv[0]), .rsp_data(rd[0]), .select_pulse(pulse[0]));

    cfg_item_port #(.DATA_BYTES(DB), .ENTRY_COUNT(EC), .MAX_LEN(ML), .COMBINED(1'b1)) u_cfg_item_port_comb (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy[1]),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rv[1]), .rsp_data(rd[1]), .select_pulse(pulse[1]));

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string phase  = "R1";

    int          m_ok [2];
    int          m_bank [2];
    int          m_idx [2];
    int          m_off [2];
    logic [63:0] e_rd [2];
    bit          e_rv [2];
    bit          e_pulse [2];

    function automatic int exp_len(input int b, input int i);
        if (b == 0 && i == 0) return 4;
        if (b == 1 && i == EC - 1) return 0;
        return (5 * i + 3 * b) % (ML + 1);
    endfunction

    function automatic logic [7:0] exp_byte(input int b, input int i, input int o);
        if (b == 0 && i == 0) begin
            case (o)
                0: return 8'h4B;
                1: return 8'h43;
                2: return 8'h46;
                default: return 8'h47;
            endcase
        end
        return 8'((128 * b + 16 * i + o) ^ 8'h5A);
    endfunction

    // Reference model, updated at each rising edge.
    always @(posedge clk) begin
        for (int m = 0; m < 2; m++) begin
            if (rst) begin
                m_ok[m] = 1; m_bank[m] = 0; m_idx[m] = 0; m_off[m] = 0;
                e_rd[m] = 0; e_rv[m] = 0; e_pulse[m] = 0;
            end else begin
                bit is_sel, is_data;
                int n, avail, key_i;
                logic [63:0] v;
                e_rd[m] = 0; e_rv[m] = 0; e_pulse[m] = 0;
                if (req_valid) begin
                    n = 1 << req_size;
                    if (m == 0) begin
                        is_sel  = !req_addr && req_write && req_size == 2'd1;
                        is_data = req_addr;
                    end else begin
                        is_sel  = req_write && req_size == 2'd1;
                        is_data = req_size == 2'd0;
                    end
                    if (is_sel) begin
                        key_i    = int'(req_wdata[14:0]);
                        m_off[m] = 0;
                        if (key_i < EC) begin
                            m_ok[m] = 1; m_bank[m] = int'(req_wdata[15]); m_idx[m] = key_i;
                            e_pulse[m] = 1;
                        end else begin
                            m_ok[m] = 0;
                        end
                    end else if (!req_write) begin
                        e_rv[m] = 1;
                        if (is_data && n <= DB) begin
                            avail = 0;
                            if (m_ok[m] != 0 && m_off[m] < exp_len(m_bank[m], m_idx[m]))
                                avail = exp_len(m_bank[m], m_idx[m]) - m_off[m];
                            v = 0;
                            for (int k = 0; k < n; k++)
                                v = (v << 8) | ((k < avail) ? 64'(exp_byte(m_bank[m], m_idx[m], m_off[m] + k)) : 64'd0);
                            m_off[m] = m_off[m] + ((n < avail) ? n : avail);
                            e_rd[m] = v;
                        end
                    end
                end
            end
        end
    end

    // Compare every cycle after reset.
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int m = 0; m < 2; m++) begin
                checks++;
                if (rdy[m] !== 1'b1 || rv[m] !== e_rv[m] || rd[m] !== e_rd[m][DB*8-1:0] ||
                    pulse[m] !== e_pulse[m]) begin
                    fails++;
                    $display("FAIL %s inst%0d: ready=%0b rv=%0b data=%h pulse=%0b expected ready=1 rv=%0b data=%h pulse=%0b",
                             phase, m, rdy[m], rv[m], rd[m], pulse[m],
                             e_rv[m], e_rd[m][DB*8-1:0], e_pulse[m]);
                end
            end
        end
    end

    task automatic acc(input bit w, input bit a, input int sz, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = 2'(sz); req_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic sel(input logic [15:0] key);
        acc(1'b1, 1'b0, 1, key);
    endtask

    task automatic rdd(input int sz);
        acc(1'b0, 1'b1, sz, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            checks++;
            if (rdy[m] !== 1'b0 || rv[m] !== 1'b0 || rd[m] !== '0 || pulse[m] !== 1'b0) begin
                fails++;
                $display("FAIL R1 reset inst%0d: ready=%0b rv=%0b data=%h pulse=%0b expected all 0",
                         m, rdy[m], rv[m], rd[m], pulse[m]);
            end
        end
        rst = 1'b0;

        phase = "R1"; rdd(2); phase = "R7"; rdd(0); idle();
        phase = "R14"; sel(16'h0002); rdd(2); rdd(2);
        phase = "R6"; rdd(2); phase = "R7"; rdd(1); idle();
        phase = "R3"; sel(16'h8001); rdd(1); rdd(1); rdd(0); phase = "R6"; rdd(2); idle();
        phase = "R4"; sel(16'h0008); rdd(2); sel(16'h7FFF); rdd(0); idle();
        phase = "R7"; sel(16'h8007); rdd(2); idle();
        phase = "R2"; sel(16'h0003); rdd(2); sel(16'h0003); rdd(2); sel(16'h0009); sel(16'h0004); rdd(0); idle();
        phase = "R8"; sel(16'h0005); rdd(0); acc(1'b1, 1'b0, 2, 16'h0001); acc(1'b1, 1'b0, 0, 16'h0001);
        acc(1'b0, 1'b0, 1, 16'h0); rdd(0); idle();
        phase = "R9"; acc(1'b1, 1'b1, 0, 16'h00FF); acc(1'b1, 1'b1, 2, 16'h8001); rdd(0); idle();
        phase = "R10"; sel(16'h0006); rdd(3); rdd(2); idle();
        phase = "R12"; sel(16'h0001); acc(1'b0, 1'b0, 0, 16'h0); acc(1'b0, 1'b0, 0, 16'h0);
        acc(1'b1, 1'b1, 1, 16'h8002); acc(1'b0, 1'b1, 0, 16'h0); acc(1'b0, 1'b0, 0, 16'h0); idle();
        phase = "R11"; sel(16'h0002); sel(16'h8001); sel(16'h0009); sel(16'h8003); idle();
        phase = "R13"; sel(16'h0005);
        for (int j = 0; j < 10; j++) rdd(0);
        idle();
        phase = "R5";
        for (int j = 0; j < 400; j++) begin
            acc(($urandom % 4) == 0, $urandom % 2, $urandom % 4,
                {1'($urandom % 2), 15'($urandom % 10)});
            if (($urandom % 3) == 0) idle();
        end
        idle(); idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL R13 watchdog: run still active, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule